// File: doc/BRIEF.md
# Self-Stepping Compare and Masked Capture Timer

This block pairs a 16-bit free-running up-counter with two timing channels. The compare channel fires a one-cycle match pulse whenever the counter reaches the compare register. When alternate stepping is enabled, each match moves the compare register forward by one of two programmed increments, using them in turn. The waveform output follows the increments: it goes high after a step by the high-phase increment and low after a step by the low-phase increment. Software sets the two increments, and the block then produces a periodic waveform with a chosen duty cycle without further writes.

The capture channel passes an external input through a two-stage synchroniser and latches the counter on each rising edge. When masking is enabled and the mask length is nonzero, an accepted capture opens a blocking window. During that window later edges are discarded. The window closes when the counter reaches the captured value plus twice the mask length. This suppresses bounce or closely spaced edges on the capture line.

Top module: `cmp_cap_timer`

## Requirements
- R1: `count` is 0 out of reset and increases by 1 on every clock, wrapping from 0xFFFF to 0x0000. All sums in the block are modulo 2^16.
- R2: `match_pulse` is high for exactly the cycle after a cycle in which `count` equalled the compare register.
- R3: With stepping enabled (control bit 0), a match loads the compare register with its value plus an increment. The increments alternate, high-phase first after reset. A match on value N therefore gives a next match at N+A, then N+A+B, and so on.
- R4: `wave_out` goes to 1 on a high-phase step and to 0 on a low-phase step, both visible with the match pulse. With stepping disabled, a match changes neither the compare register nor `wave_out`.
- R5: A write to the compare register in the same cycle as a stepping match wins. That match changes neither the alternation phase nor `wave_out`.
- R6: A rising edge on `cap_in` that is raised in a cycle with count c is detected in the cycle with count c+2. `cap_value` shows c+2 from the following cycle.
- R7: When masking is enabled (control bit 1) and the mask length L is nonzero, an accepted capture raises `mask_active` together with `cap_value`. While the mask is active, detected edges leave `cap_value` unchanged.
- R8: For a capture value C, `mask_active` stays high through the cycle with count C+2L and is low from count C+2L+1. An edge detected at C+2L is ignored; an edge detected at C+2L+1 is accepted.
- R9: With masking disabled, or with L = 0, every detected edge updates `cap_value` and `mask_active` stays 0.
- R10: Register writes use `wr_sel`: 0 compare (reset 0xFFFF), 1 high-phase increment, 2 low-phase increment, 3 mask length, 4 control. All registers except the compare register reset to 0. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| cap_in | input | 1 | External capture input (asynchronous) |
| count | output | 16 | Free-running counter value |
| match_pulse | output | 1 | One-cycle compare match pulse |
| wave_out | output | 1 | Waveform level driven by alternate stepping |
| cap_value | output | 16 | Last accepted capture value |
| mask_active | output | 1 | Capture mask window open |

## Verification
A match at count N shows on `match_pulse` and `wave_out` in the cycle where `count` reads N+1. A capture input raised at count c yields `cap_value` = c+2 and, if armed, `mask_active` at count c+3. The mask drops at the count one past C+2L. The bench drives inputs on the falling edge and compares every output on the falling edge against a cycle model stepped on the rising edge. The directed checks wait for the exact count values listed above before sampling.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [2:0] {
    SEL_CMP  = 3'd0,
    SEL_RISE = 3'd1,
    SEL_FALL = 3'd2,
    SEL_MLEN = 3'd3,
    SEL_CTRL = 3'd4
  } sel_e;

  localparam int CTRL_W      = 2;
  localparam int CTRL_STEP   = 0;
  localparam int CTRL_MASK   = 1;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb cnt_d = cnt + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         step_en,
  input  logic         wr_cmp,
  input  logic         wr_rise,
  input  logic         wr_fall,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_q,
  output logic         pulse_q,
  output logic         wave_q
);
  logic [W-1:0] rise_q, fall_q;
  logic         phase_q;
  logic [W-1:0] cmp_d, step;
  logic         phase_d, wave_d, hit;

  always_comb begin
    hit     = (cnt == cmp_q);
    step    = phase_q ? fall_q : rise_q;
    cmp_d   = cmp_q;
    phase_d = phase_q;
    wave_d  = wave_q;
    if (wr_cmp) begin
      cmp_d = wr_data;
    end else if (hit && step_en) begin
      cmp_d   = cmp_q + step;
      phase_d = ~phase_q;
      wave_d  = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '1;
      rise_q  <= '0;
      fall_q  <= '0;
      phase_q <= 1'b0;
      wave_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      phase_q <= phase_d;
      wave_q  <= wave_d;
      pulse_q <= hit;
      if (wr_rise) rise_q <= wr_data;
      if (wr_fall) fall_q <= wr_data;
    end
  end
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         cap_in,
  input  logic         arm,
  input  logic [W-1:0] mlen,
  output logic [W-1:0] cap_q,
  output logic         mask_q,
  output logic [W-1:0] end_q
);
  localparam int CHAIN = SYNC + 1;

  logic [CHAIN-1:0] sy_q;
  logic             rise_det, accept;
  logic [W-1:0]     win, cap_d, end_d;
  logic             mask_d;

  always_comb begin
    rise_det = sy_q[SYNC-1] & ~sy_q[SYNC];
    accept   = rise_det & ~mask_q;
    win      = {mlen[W-2:0], 1'b0};
    cap_d    = cap_q;
    end_d    = end_q;
    mask_d   = mask_q;
    if (accept) begin
      cap_d  = cnt;
      mask_d = arm;
      if (arm) end_d = cnt + win;
    end else if (mask_q && (cnt == end_q)) begin
      mask_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q   <= '0;
      cap_q  <= '0;
      end_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      sy_q   <= {sy_q[CHAIN-2:0], cap_in};
      cap_q  <= cap_d;
      end_q  <= end_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/cmp_cap_timer.sv
module cmp_cap_timer
  import cct_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         cap_in,
  output logic [W-1:0] count,
  output logic         match_pulse,
  output logic         wave_out,
  output logic [W-1:0] cap_value,
  output logic         mask_active
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      mlen_q;
  logic [W-1:0]      cmp_q, mask_end;
  logic              wr_cmp, wr_rise, wr_fall, wr_mlen, wr_ctrl;
  logic              mask_on;

  always_comb begin
    wr_cmp  = wr_en && (wr_sel == SEL_CMP);
    wr_rise = wr_en && (wr_sel == SEL_RISE);
    wr_fall = wr_en && (wr_sel == SEL_FALL);
    wr_mlen = wr_en && (wr_sel == SEL_MLEN);
    wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    mask_on = ctrl_q[CTRL_MASK] && (mlen_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mlen_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_mlen) mlen_q <= wr_data;
    end
  end

  cct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(count)
  );

  cct_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(count),
    .step_en(ctrl_q[CTRL_STEP]),
    .wr_cmp(wr_cmp), .wr_rise(wr_rise), .wr_fall(wr_fall),
    .wr_data(wr_data),
    .cmp_q(cmp_q), .pulse_q(match_pulse), .wave_q(wave_out)
  );

  cct_capture #(.W(W), .SYNC(SYNC)) u_cap (
    .clk(clk), .rst_n(rst_n), .cnt(count), .cap_in(cap_in),
    .arm(mask_on), .mlen(mlen_q),
    .cap_q(cap_value), .mask_q(mask_active), .end_q(mask_end)
  );
endmodule

// File: rtl/cct_checks.sv
module cct_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_q,
  input logic         match_pulse,
  input logic         wave_out,
  input logic [W-1:0] cap_value,
  input logic         mask_active,
  input logic [W-1:0] mask_end,
  input logic         mask_on
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> count == $past(count) + W'(1));

  a_r2_match_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> match_pulse == ($past(count) == $past(cmp_q)));

  a_r4_wave_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$stable(wave_out) |-> match_pulse);

  a_r7_hold_while_masked: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(mask_active) |-> $stable(cap_value));

  a_r8_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(mask_active) && ($past(count) == $past(mask_end)) |-> !mask_active);

  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(mask_active) && !$past(mask_on) |-> !mask_active);
endmodule

bind cmp_cap_timer cct_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .count(count), .cmp_q(cmp_q),
  .match_pulse(match_pulse), .wave_out(wave_out), .cap_value(cap_value),
  .mask_active(mask_active), .mask_end(mask_end), .mask_on(mask_on)
);

// File: tb/cmp_cap_timer_test.sv
`timescale 1ns/1ps
module cmp_cap_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic        cap_in = 1'b0;
  logic [15:0] count, cap_value;
  logic        match_pulse, wave_out, mask_active;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cmp_cap_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cap_in(cap_in), .count(count), .match_pulse(match_pulse), .wave_out(wave_out),
    .cap_value(cap_value), .mask_active(mask_active)
  );

  // reference model, stepped on the rising edge
  logic [15:0] m_cnt, m_cmp, m_rise, m_fall, m_len, m_cap, m_end;
  logic [1:0]  m_ctrl;
  logic [2:0]  m_sy;
  logic        m_phase, m_wave, m_pulse, m_mask;

  function automatic logic [15:0] twice(input logic [15:0] v);
    return v + v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_cmp <= 16'hFFFF; m_rise <= 0; m_fall <= 0; m_len <= 0;
      m_cap <= 0; m_end <= 0; m_ctrl <= 0; m_sy <= 0;
      m_phase <= 0; m_wave <= 0; m_pulse <= 0; m_mask <= 0;
    end else begin
      m_cnt   <= m_cnt + 16'd1;
      m_pulse <= (m_cnt == m_cmp);
      if (wr_en && wr_sel == 3'd0) m_cmp <= wr_data;
      else if (m_cnt == m_cmp && m_ctrl[0]) begin
        m_cmp   <= m_cmp + (m_phase ? m_fall : m_rise);
        m_phase <= !m_phase;
        m_wave  <= !m_phase;
      end
      if (wr_en && wr_sel == 3'd1) m_rise <= wr_data;
      if (wr_en && wr_sel == 3'd2) m_fall <= wr_data;
      if (wr_en && wr_sel == 3'd3) m_len  <= wr_data;
      if (wr_en && wr_sel == 3'd4) m_ctrl <= wr_data[1:0];
      m_sy <= {m_sy[1:0], cap_in};
      if (m_sy[1] && !m_sy[2] && !m_mask) begin
        m_cap <= m_cnt;
        if (m_ctrl[1] && m_len != 0) begin
          m_mask <= 1'b1;
          m_end  <= m_cnt + twice(m_len);
        end
      end else if (m_mask && m_cnt == m_end) m_mask <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk(count == m_cnt, "R1 count", count, m_cnt);
      chk(match_pulse == m_pulse, "R2 match pulse", match_pulse, m_pulse);
      chk(wave_out == m_wave, "R4 wave", wave_out, m_wave);
      chk(cap_value == m_cap, "R6 capture", cap_value, m_cap);
      chk(mask_active == m_mask, "R7 mask", mask_active, m_mask);
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (count !== v) @(negedge clk);
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (match_pulse !== 1'b1) @(negedge clk);
  endtask

  // edge detected in cycle with count t; value shows at count t+1
  task automatic cap_at(input logic [15:0] t);
    wait_cnt(t - 16'd2);
    cap_in = 1'b1;
    @(negedge clk);
    cap_in = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    logic [15:0] n, c, c2, wcmp;
    logic        wb;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(count == 0 && !match_pulse && !wave_out, "R10 reset outputs", count, 0);
    chk(cap_value == 0 && !mask_active, "R10 reset capture", cap_value, 0);
    mon_on = 1'b1;

    // R3 alternating stepping: N=40, A=7, B=3
    wr(3'd1, 16'd7);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'd40);
    wr(3'd4, 16'd1);
    wait_pulse(); chk(count == 41 && wave_out, "R3 first match rise", count, 41);
    wait_pulse(); chk(count == 48 && !wave_out, "R3 second match fall", count, 48);
    wait_pulse(); chk(count == 51 && wave_out, "R3 third match rise", count, 51);
    wait_pulse(); chk(count == 58 && !wave_out, "R3 fourth match fall", count, 58);

    // R5 write collides with a stepping match
    wb = wave_out;
    wait_cnt(m_cmp);
    wcmp = count + 16'd20;
    wr(3'd0, wcmp);
    chk(wave_out == wb, "R5 wave held on collision", wave_out, wb);
    wait_pulse();
    chk(count == wcmp + 16'd1, "R5 written compare wins", count, wcmp + 16'd1);
    chk(wave_out == !wb, "R5 phase unchanged", wave_out, !wb);

    // R4 stepping off: compare and wave hold
    wr(3'd4, 16'd0);
    wb = wave_out;
    wr(3'd0, count + 16'd5);
    wait_pulse();
    chk(wave_out == wb, "R4 wave holds when disabled", wave_out, wb);

    // R9 mask disabled: back-to-back captures
    c = count + 16'd10;
    cap_at(c);
    wait_cnt(c + 16'd1);
    chk(cap_value == c && !mask_active, "R9 capture unmasked", cap_value, c);
    cap_at(c + 16'd4);
    wait_cnt(c + 16'd5);
    chk(cap_value == c + 16'd4, "R9 second capture accepted", cap_value, c + 16'd4);
    // R9 enabled but zero length
    wr(3'd4, 16'd2);
    c = count + 16'd10;
    cap_at(c);
    wait_cnt(c + 16'd1);
    chk(cap_value == c && !mask_active, "R9 zero length no mask", mask_active, 0);

    // R7 / R8 mask window with L=5
    wr(3'd3, 16'd5);
    c = count + 16'd10;
    cap_at(c);
    wait_cnt(c + 16'd1);
    chk(cap_value == c && mask_active, "R7 mask set on capture", mask_active, 1);
    cap_at(c + 16'd10);
    wait_cnt(c + 16'd11);
    chk(cap_value == c, "R8 edge at window end ignored", cap_value, c);
    chk(!mask_active, "R8 mask low after end", mask_active, 0);
    c2 = c + 16'd14;
    cap_at(c2);
    cap_at(c2 + 16'd3);
    wait_cnt(c2 + 16'd4);
    chk(cap_value == c2 && mask_active, "R7 edge during mask ignored", cap_value, c2);
    cap_at(c2 + 16'd11);
    wait_cnt(c2 + 16'd12);
    chk(cap_value == c2 + 16'd11 && mask_active, "R8 edge after end accepted", cap_value, c2 + 16'd11);

    // R1 wrap
    wait_cnt(16'hFFFF);
    @(negedge clk);
    chk(count == 0, "R1 wrap to zero", count, 0);

    // constrained random mix
    wr(3'd4, 16'd3);
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) begin
        n = 16'($urandom_range(1, 40));
        wr(3'($urandom_range(1, 2)), n);
      end else if (r < 5) begin
        wr(3'd0, count + 16'($urandom_range(2, 60)));
      end else if (r < 6) begin
        wr(3'd3, 16'($urandom_range(0, 12)));
      end else if (r < 7) begin
        wr(3'd4, 16'($urandom_range(0, 3)));
      end else begin
        cap_in = ($urandom_range(0, 3) == 0);
        @(negedge clk);
      end
    end
    cap_in = 1'b0;
    repeat (5) @(negedge clk);
    summary();
  end
endmodule